// File: doc/BRIEF.md
# SPI Memory-Access Command Slave

This block lets an external SPI host read and write a byte-addressed, little-endian local memory. The interface runs in SPI mode 0 and sends the most significant bit first. Every transaction opens with a command byte and a 32-bit address. The command sets both the direction and the access width: a 16-bit word, a 32-bit word, or a burst of 8-byte words. On the wire each word is sent most significant byte first. The block reverses the bytes within each word so that they land in little-endian order in memory.

The local memory is seen as 8-byte rows. It has a synchronous port with a row address, eight byte-lane enables, 64-bit write data, and read data that appears one clock after the read strobe. The SPI inputs are sampled by the system clock through a two-flop synchronizer, so the system clock must run well above the SPI clock. A read transaction has a four-byte gap between the address and the first returned data byte. The block fetches the memory row during that gap. A write transaction ends with a single dummy byte, which the block never commits.

Top module: `spi_mem_slave`

## Requirements
- R1: Only command bytes 0x00 to 0x05 are valid: 0x00/0x01 are 16-bit read/write, 0x02/0x03 are 32-bit read/write, 0x04/0x05 are burst read/write, and bit 0 set means write. Any other command byte causes no memory access, and the slave returns only zero bytes.
- R2: The four bytes after the command form the address, most significant byte first. Memory row address `mem_addr` is address bits [31:3].
- R3: A 16-bit write takes two data bytes. With base lane b = {addr[2:1],0}, the first wire byte goes to lane b+1 and the second to lane b. Exactly those two `mem_be` bits are set, and one `mem_wr` pulse is issued.
- R4: A 32-bit write takes four data bytes. With base lane b = {addr[2],00}, wire byte k goes to lane b+3-k, and exactly four `mem_be` bits are set.
- R5: Each 8 bytes of a burst write produce one `mem_wr` with all eight byte enables set. Wire byte k of a word goes to lane 7-k, and successive words go to successive rows.
- R6: A word that is not fully received is never written. This covers the trailing dummy byte of a write and chip select rising in the middle of a word. While deselected, `mem_wr` and `mem_rd` stay low.
- R7: A burst write commits at most 30 rows (240 bytes). Data bytes after that are ignored.
- R8: On a read, the slave returns zero for the five header bytes and the four dummy bytes. Data then follows, each word most significant byte first, so wire byte k comes from lane b+S-1-k for word size S.
- R9: A 16-bit or 32-bit read returns exactly one word. Any further clocked bytes read as zero.
- R10: A burst read returns successive rows, one `mem_rd` strobe per fetched row.
- R11: The first read row is requested once the last address byte has arrived, before the dummy gap ends.
- R12: After reset, `mem_wr`, `mem_rd` and `spi_miso` are low.
- R13: `spi_miso` changes only after a detected falling SPI clock edge or while deselected.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| spi_sclk | input | 1 | SPI clock from host (mode 0) |
| spi_cs_n | input | 1 | Active-low chip select |
| spi_mosi | input | 1 | Host-to-slave serial data |
| spi_miso | output | 1 | Slave-to-host serial data |
| mem_rd | output | 1 | Row read strobe |
| mem_wr | output | 1 | Row write strobe |
| mem_addr | output | ADDR_W-3 | Row address (byte address bits [31:3]) |
| mem_be | output | 8 | Byte-lane enables for a write |
| mem_wdata | output | 64 | Write data, lane n in bits [8n+7:8n] |
| mem_rdata | input | 64 | Read data, valid one clock after `mem_rd` |

## Verification
The assertions assume the SPI clock is slow against the system clock: each SPI half period lasts at least six system clocks. Under that assumption a strobe is a single-cycle pulse, and a byte load never lands on the same cycle as a falling-edge shift. The assertions also assume chip select changes only while the SPI clock is low. The bench holds each half period at six system clocks. It moves chip select only with the SPI clock low and waits several clocks around each select edge.

// File: rtl/spi_mem_pkg.sv
package spi_mem_pkg;

  localparam int ROW_BYTES = 8;

  typedef enum logic [1:0] {
    SZ_16    = 2'd0,
    SZ_32    = 2'd1,
    SZ_BURST = 2'd2,
    SZ_NONE  = 2'd3
  } acc_size_e;

  function automatic acc_size_e decode_size(input logic [7:0] c);
    if (c[7:3] != 5'd0 || c[2:1] == 2'b11) return SZ_NONE;
    case (c[2:1])
      2'b00:   return SZ_16;
      2'b01:   return SZ_32;
      default: return SZ_BURST;
    endcase
  endfunction

  function automatic logic [2:0] align_base(input acc_size_e s, input logic [2:0] a);
    case (s)
      SZ_16:   return {a[2:1], 1'b0};
      SZ_32:   return {a[2], 2'b00};
      default: return 3'd0;
    endcase
  endfunction

endpackage

// File: rtl/spi_mem_sync.sv
module spi_mem_sync #(
  parameter int         W       = 1,
  parameter logic [W-1:0] RST_VAL = '0
) (
  input  logic         clk,
  input  logic         rst,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);
  logic [W-1:0] stage1;

  always_ff @(posedge clk) begin
    if (rst) begin
      stage1 <= RST_VAL;
      q      <= RST_VAL;
    end else begin
      stage1 <= d;
      q      <= stage1;
    end
  end
endmodule

// File: rtl/spi_mem_serdes.sv
module spi_mem_serdes (
  input  logic       clk,
  input  logic       rst,
  input  logic       sel,
  input  logic       rise,
  input  logic       fall,
  input  logic       mosi,
  input  logic       tx_load,
  input  logic [7:0] tx_byte,
  output logic       byte_done,
  output logic [7:0] rx_byte,
  output logic       miso
);
  logic [2:0] bit_cnt;
  logic [7:0] rx_sh;
  logic [7:0] tx_sh;

  always_ff @(posedge clk) begin
    if (rst || !sel) begin
      bit_cnt   <= '0;
      rx_sh     <= '0;
      rx_byte   <= '0;
      byte_done <= 1'b0;
      tx_sh     <= '0;
      miso      <= 1'b0;
    end else begin
      byte_done <= 1'b0;
      if (rise) begin
        rx_sh   <= {rx_sh[6:0], mosi};
        bit_cnt <= bit_cnt + 3'd1;
        if (bit_cnt == 3'd7) begin
          byte_done <= 1'b1;
          rx_byte   <= {rx_sh[6:0], mosi};
        end
      end
      if (tx_load) begin
        tx_sh <= tx_byte;
      end else if (fall) begin
        miso  <= tx_sh[7];
        tx_sh <= {tx_sh[6:0], 1'b0};
      end
    end
  end
endmodule

// File: rtl/spi_mem_ctrl.sv
module spi_mem_ctrl
  import spi_mem_pkg::*;
#(
  parameter int ADDR_W    = 32,
  parameter int MAX_BURST = 240,
  parameter int RD_DUMMY  = 4
) (
  input  logic                clk,
  input  logic                rst,
  input  logic                sel,
  input  logic                byte_done,
  input  logic [7:0]          rx_byte,
  output logic                tx_load,
  output logic [7:0]          tx_byte,
  output logic                mem_rd,
  output logic                mem_wr,
  output logic [ADDR_W-4:0]   mem_addr,
  output logic [7:0]          mem_be,
  output logic [63:0]         mem_wdata,
  input  logic [63:0]         mem_rdata
);
  localparam int HDR_BYTES  = 5;
  localparam int RD_FIRST   = HDR_BYTES + RD_DUMMY;
  localparam int IDX_W      = $clog2(RD_FIRST + 1);
  localparam int BURST_ROWS = MAX_BURST / ROW_BYTES;
  localparam int ROWS_W     = $clog2(BURST_ROWS + 1);

  logic [IDX_W-1:0]  idx;
  acc_size_e         sz;
  logic              is_wr;
  logic              done;
  logic [ADDR_W-1:0] addr_sh;
  logic [ADDR_W-1:0] addr_full;
  logic [2:0]        base, k, last_k, lane;
  logic [ROWS_W-1:0] rows;
  logic [63:0]       rbuf;
  logic              rd_pend;
  logic              word_end, last_row;

  always_comb begin
    case (sz)
      SZ_16:   last_k = 3'd1;
      SZ_32:   last_k = 3'd3;
      default: last_k = 3'd7;
    endcase
    lane      = base + last_k - k;
    addr_full = {addr_sh[ADDR_W-9:0], rx_byte};
    word_end  = (k == last_k);
    last_row  = (sz != SZ_BURST) || (rows == ROWS_W'(BURST_ROWS - 1));
  end

  always_ff @(posedge clk) begin
    if (rst || !sel) begin
      idx       <= '0;
      sz        <= SZ_NONE;
      is_wr     <= 1'b0;
      done      <= 1'b0;
      addr_sh   <= '0;
      base      <= '0;
      k         <= '0;
      rows      <= '0;
      rbuf      <= '0;
      rd_pend   <= 1'b0;
      tx_load   <= 1'b0;
      tx_byte   <= '0;
      mem_rd    <= 1'b0;
      mem_wr    <= 1'b0;
      mem_addr  <= '0;
      mem_be    <= '0;
      mem_wdata <= '0;
    end else begin
      mem_rd  <= 1'b0;
      mem_wr  <= 1'b0;
      tx_load <= 1'b0;
      rd_pend <= mem_rd;
      if (rd_pend) rbuf <= mem_rdata;

      if (byte_done) begin
        if (idx != IDX_W'(RD_FIRST)) idx <= idx + IDX_W'(1);

        if (idx == '0) begin
          sz    <= decode_size(rx_byte);
          is_wr <= rx_byte[0];
        end else if (idx < IDX_W'(HDR_BYTES)) begin
          addr_sh <= addr_full;
        end

        if (idx == IDX_W'(HDR_BYTES - 1)) begin
          mem_addr <= addr_full[ADDR_W-1:3];
          base     <= align_base(sz, addr_full[2:0]);
          if (sz == SZ_NONE) done <= 1'b1;
          else if (!is_wr)   mem_rd <= 1'b1;
        end

        // write data path: commit only whole words
        if (is_wr && idx >= IDX_W'(HDR_BYTES) && !done) begin
          if (k == 3'd0 && rows != '0) mem_addr <= mem_addr + 1'b1;
          mem_wdata[{lane, 3'b000} +: 8] <= rx_byte;
          mem_be <= (k == 3'd0 ? 8'h00 : mem_be) | (8'h01 << lane);
          if (word_end) begin
            mem_wr <= 1'b1;
            k      <= '0;
            rows   <= rows + ROWS_W'(1);
            if (last_row) done <= 1'b1;
          end else begin
            k <= k + 3'd1;
          end
        end

        // read data path: load next outgoing byte
        if (!is_wr && idx >= IDX_W'(RD_FIRST - 1)) begin
          tx_load <= 1'b1;
          if (done) begin
            tx_byte <= 8'h00;
          end else begin
            tx_byte <= rbuf[{lane, 3'b000} +: 8];
            if (word_end) begin
              k    <= '0;
              rows <= rows + ROWS_W'(1);
              if (last_row) begin
                done <= 1'b1;
              end else begin
                mem_addr <= mem_addr + 1'b1;
                mem_rd   <= 1'b1;
              end
            end else begin
              k <= k + 3'd1;
            end
          end
        end
      end
    end
  end
endmodule

// File: rtl/spi_mem_slave.sv
module spi_mem_slave #(
  parameter int ADDR_W    = 32,
  parameter int MAX_BURST = 240,
  parameter int RD_DUMMY  = 4
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              spi_sclk,
  input  logic              spi_cs_n,
  input  logic              spi_mosi,
  output logic              spi_miso,
  output logic              mem_rd,
  output logic              mem_wr,
  output logic [ADDR_W-4:0] mem_addr,
  output logic [7:0]        mem_be,
  output logic [63:0]       mem_wdata,
  input  logic [63:0]       mem_rdata
);
  logic cs_s, sclk_s, mosi_s, sclk_d;
  logic sel, sclk_rise, sclk_fall;
  logic byte_done, tx_load;
  logic [7:0] rx_byte, tx_byte;

  spi_mem_sync #(.W(3), .RST_VAL(3'b100)) u_sync (
    .clk (clk),
    .rst (rst),
    .d   ({spi_cs_n, spi_sclk, spi_mosi}),
    .q   ({cs_s, sclk_s, mosi_s})
  );

  always_ff @(posedge clk) begin
    if (rst) sclk_d <= 1'b0;
    else     sclk_d <= sclk_s;
  end

  assign sel       = ~cs_s;
  assign sclk_rise = sclk_s & ~sclk_d;
  assign sclk_fall = ~sclk_s & sclk_d;

  spi_mem_serdes u_serdes (
    .clk       (clk),
    .rst       (rst),
    .sel       (sel),
    .rise      (sclk_rise),
    .fall      (sclk_fall),
    .mosi      (mosi_s),
    .tx_load   (tx_load),
    .tx_byte   (tx_byte),
    .byte_done (byte_done),
    .rx_byte   (rx_byte),
    .miso      (spi_miso)
  );

  spi_mem_ctrl #(.ADDR_W(ADDR_W), .MAX_BURST(MAX_BURST), .RD_DUMMY(RD_DUMMY)) u_ctrl (
    .clk       (clk),
    .rst       (rst),
    .sel       (sel),
    .byte_done (byte_done),
    .rx_byte   (rx_byte),
    .tx_load   (tx_load),
    .tx_byte   (tx_byte),
    .mem_rd    (mem_rd),
    .mem_wr    (mem_wr),
    .mem_addr  (mem_addr),
    .mem_be    (mem_be),
    .mem_wdata (mem_wdata),
    .mem_rdata (mem_rdata)
  );
endmodule

// File: rtl/spi_mem_slave_chk.sv
module spi_mem_slave_chk (
  input logic       clk,
  input logic       rst,
  input logic       sel,
  input logic       fall,
  input logic       miso,
  input logic       mem_rd,
  input logic       mem_wr,
  input logic [7:0] mem_be
);
  // R10: a read strobe is one cycle wide and never meets a write
  p_rd_pulse_r10: assert property (@(posedge clk) disable iff (rst)
    mem_rd |=> !mem_rd);
  p_rw_excl_r10: assert property (@(posedge clk) disable iff (rst)
    !(mem_rd && mem_wr));
  // R6: one commit per word, and no access while deselected
  p_wr_pulse_r6: assert property (@(posedge clk) disable iff (rst)
    mem_wr |=> !mem_wr);
  p_deselect_quiet_r6: assert property (@(posedge clk) disable iff (rst)
    !sel |=> (!mem_wr && !mem_rd));
  // R3: a commit enables 2, 4 or 8 lanes
  p_be_count_r3: assert property (@(posedge clk) disable iff (rst)
    mem_wr |-> ($countones(mem_be) == 2 || $countones(mem_be) == 4 ||
                $countones(mem_be) == 8));
  // R13: MISO moves only after a falling edge or on deselect
  p_miso_fall_r13: assert property (@(posedge clk) disable iff (rst)
    !$stable(miso) |-> ($past(fall) || !$past(sel)));
endmodule

bind spi_mem_slave spi_mem_slave_chk u_chk (
  .clk    (clk),
  .rst    (rst),
  .sel    (sel),
  .fall   (sclk_fall),
  .miso   (spi_miso),
  .mem_rd (mem_rd),
  .mem_wr (mem_wr),
  .mem_be (mem_be)
);

// File: tb/spi_mem_slave_test.sv
module spi_mem_slave_test;
  localparam int CLK_PERIOD = 10;
  localparam int HALF       = 6;

  logic clk = 1'b0, rst = 1'b1;
  logic spi_sclk = 1'b0, spi_cs_n = 1'b1, spi_mosi = 1'b0;
  logic spi_miso, mem_rd, mem_wr;
  logic [28:0] mem_addr;
  logic [7:0]  mem_be;
  logic [63:0] mem_wdata;
  logic [63:0] mem_rdata;

  int total = 0, failed = 0, unstable = 0;
  int wr_count, rd_count, rd_snap;
  logic [28:0] last_wr_addr;
  logic [63:0] mem    [32];
  logic [63:0] shadow [32];
  logic [7:0]  tx_buf [260];
  logic [7:0]  rx_buf [260];
  bit finished = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  spi_mem_slave uut (
    .clk(clk), .rst(rst), .spi_sclk(spi_sclk), .spi_cs_n(spi_cs_n),
    .spi_mosi(spi_mosi), .spi_miso(spi_miso), .mem_rd(mem_rd), .mem_wr(mem_wr),
    .mem_addr(mem_addr), .mem_be(mem_be), .mem_wdata(mem_wdata), .mem_rdata(mem_rdata)
  );

  // external memory model: 32 rows, read data one clock after strobe
  always @(posedge clk) begin
    if (rst) begin
      for (int r = 0; r < 32; r++) mem[r] <= '0;
      wr_count <= 0; rd_count <= 0; mem_rdata <= '0; last_wr_addr <= '0;
    end else begin
      if (mem_wr) begin
        for (int b = 0; b < 8; b++)
          if (mem_be[b]) mem[mem_addr[4:0]][b*8 +: 8] <= mem_wdata[b*8 +: 8];
        wr_count <= wr_count + 1;
        last_wr_addr <= mem_addr;
      end
      if (mem_rd) begin
        mem_rdata <= mem[mem_addr[4:0]];
        rd_count <= rd_count + 1;
      end
    end
  end

  task automatic chk(input string tag, input logic [63:0] act, input logic [63:0] exp);
    total++;
    if (act !== exp) begin
      failed++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic spi_byte(input logic [7:0] tx, output logic [7:0] rx);
    for (int i = 7; i >= 0; i--) begin
      @(negedge clk) spi_mosi = tx[i];
      repeat (HALF) @(negedge clk);
      rx[i] = spi_miso;
      spi_sclk = 1'b1;
      repeat (HALF - 1) @(negedge clk);
      if (spi_miso !== rx[i]) unstable++;
      @(negedge clk) spi_sclk = 1'b0;
    end
  endtask

  task automatic xact(input int n);
    @(negedge clk) spi_cs_n = 1'b0;
    repeat (4) @(negedge clk);
    for (int i = 0; i < n; i++) begin
      spi_byte(tx_buf[i], rx_buf[i]);
      if (i == 5) rd_snap = rd_count;
    end
    repeat (4) @(negedge clk);
    spi_cs_n = 1'b1;
    repeat (8) @(negedge clk);
  endtask

  task automatic put_hdr(input logic [7:0] cmd, input logic [31:0] a);
    tx_buf[0] = cmd;
    for (int i = 0; i < 4; i++) tx_buf[1+i] = a[31-8*i -: 8];
    for (int i = 5; i < 260; i++) tx_buf[i] = 8'h00;
  endtask

  // {cmd, address, wire data (first byte in bits 63:56)}
  localparam logic [103:0] VEC [6] = '{
    {8'h01, 32'h1234_5672, 64'hAABB_0000_0000_0000},
    {8'h03, 32'h0000_0014, 64'h1122_3344_0000_0000},
    {8'h01, 32'h0000_0010, 64'h5566_0000_0000_0000},
    {8'h00, 32'h0000_0014, 64'h0},
    {8'h02, 32'h0000_0010, 64'h0},
    {8'h02, 32'h1234_5670, 64'h0}
  };

  initial begin
    repeat (190000) @(posedge clk);
    if (!finished) begin
      total++; failed++;
      $display("FAIL watchdog actual=timeout expected=completion");
      $display("%0d/%0d checks passed", total - failed, total);
      $finish;
    end
  end

  initial begin
    int wc0, rc0, sz, base, row, lane;
    logic [7:0] cmd;
    logic [31:0] a;
    logic [63:0] d, acc;
    for (int r = 0; r < 32; r++) shadow[r] = '0;
    repeat (5) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    chk("R12 mem_wr", {63'd0, mem_wr}, 64'd0);
    chk("R12 mem_rd", {63'd0, mem_rd}, 64'd0);
    chk("R12 miso",   {63'd0, spi_miso}, 64'd0);

    // vector table: 16/32-bit writes and reads
    foreach (VEC[v]) begin
      cmd = VEC[v][103:96]; a = VEC[v][95:64]; d = VEC[v][63:0];
      sz = (cmd[2:1] == 2'b00) ? 2 : 4;
      base = (sz == 2) ? {a[2:1], 1'b0} : {a[2], 2'b00};
      row = int'(a[7:3]);
      put_hdr(cmd, a);
      if (cmd[0]) begin
        for (int k = 0; k < sz; k++) tx_buf[5+k] = d[63-8*k -: 8];
        tx_buf[5+sz] = 8'hC3;
        wc0 = wr_count;
        xact(6 + sz);
        for (int k = 0; k < sz; k++) shadow[row][(base+sz-1-k)*8 +: 8] = d[63-8*k -: 8];
        chk(sz == 2 ? "R3 row" : "R4 row", mem[row], shadow[row]);
        chk(sz == 2 ? "R3 count" : "R4 count", 64'(wr_count - wc0), 64'd1);
        chk("R2 addr", {35'd0, last_wr_addr}, {35'd0, a[31:3]});
      end else begin
        xact(9 + sz);
        acc = '0;
        for (int i = 0; i < 9; i++) acc[7:0] = acc[7:0] | rx_buf[i];
        chk("R8 header zero", acc, 64'd0);
        for (int k = 0; k < sz; k++) begin
          lane = base + sz - 1 - k;
          chk("R8 data", {56'd0, rx_buf[9+k]}, {56'd0, shadow[row][lane*8 +: 8]});
        end
      end
    end

    // R5 burst write two rows plus trailing dummy (R6)
    put_hdr(8'h05, 32'h0000_0040);
    for (int i = 0; i < 16; i++) tx_buf[5+i] = 8'h10 + 8'(i);
    tx_buf[21] = 8'hEE;
    wc0 = wr_count;
    xact(22);
    chk("R5 row8", mem[8], 64'h1011_1213_1415_1617);
    chk("R5 row9", mem[9], 64'h1819_1A1B_1C1D_1E1F);
    chk("R6 trailing dummy", 64'(wr_count - wc0), 64'd2);

    // R10 burst read, R11 fetch timing
    put_hdr(8'h04, 32'h0000_0040);
    rc0 = rd_count;
    xact(25);
    chk("R11 fetch before data", 64'(rd_snap - rc0), 64'd1);
    for (int i = 0; i < 16; i++)
      chk("R10 burst data", {56'd0, rx_buf[9+i]}, {56'd0, 8'h10 + 8'(i)});

    // R9 16-bit read then extra bytes
    put_hdr(8'h00, 32'h0000_0040);
    xact(13);
    chk("R9 word", {48'd0, rx_buf[9], rx_buf[10]}, 64'h1617);
    chk("R9 extra zero", {48'd0, rx_buf[11], rx_buf[12]}, 64'h0);

    // R1 invalid commands
    put_hdr(8'h06, 32'h0000_0040);
    xact(13);
    chk("R1 bad read", {32'd0, rx_buf[9], rx_buf[10], rx_buf[11], rx_buf[12]}, 64'h0);
    put_hdr(8'h07, 32'h0000_0040);
    tx_buf[5] = 8'h77; tx_buf[6] = 8'h88;
    wc0 = wr_count;
    xact(8);
    chk("R1 bad write count", 64'(wr_count - wc0), 64'd0);
    chk("R1 bad write row", mem[8], 64'h1011_1213_1415_1617);

    // R6 aborts
    put_hdr(8'h01, 32'h0000_0040);
    tx_buf[5] = 8'h99;
    wc0 = wr_count;
    xact(6);
    chk("R6 abort 16", 64'(wr_count - wc0), 64'd0);
    chk("R6 abort 16 row", mem[8], 64'h1011_1213_1415_1617);
    put_hdr(8'h05, 32'h0000_0048);
    for (int i = 0; i < 5; i++) tx_buf[5+i] = 8'hA0 + 8'(i);
    xact(10);
    chk("R6 abort burst", 64'(wr_count - wc0), 64'd0);
    chk("R6 abort burst row", mem[9], 64'h1819_1A1B_1C1D_1E1F);

    // R7 burst limit
    put_hdr(8'h05, 32'h0000_0000);
    for (int i = 0; i < 248; i++) tx_buf[5+i] = 8'(i + 1);
    tx_buf[253] = 8'h5A;
    wc0 = wr_count;
    xact(254);
    chk("R7 commit count", 64'(wr_count - wc0), 64'd30);
    chk("R7 first row", mem[0], 64'h0102_0304_0506_0708);
    chk("R7 last row", mem[29], 64'hE9EA_EBEC_EDEE_EFF0);
    chk("R7 beyond limit", mem[30], 64'h0);

    chk("R13 miso stable while sclk high", 64'(unstable), 64'd0);

    finished = 1;
    $display("%0d/%0d checks passed", total - failed, total);
    $finish;
  end
endmodule